// File: doc/BRIEF.md
# Integer-to-Floating-Point Converter

The block converts an integer taken from a 64-bit general register into a floating-point value. Three selects pick the variant. The source is either the whole 64-bit register or its low 32 bits. The source is read either as two's complement or as unsigned. The result is rounded either to double precision or to single precision. This gives eight variants, and all of them share one datapath. The result always leaves the block in 64-bit double-precision register format. A single-precision result is therefore rounded at 24 significand bits first and then written out exactly as a double.

A one-cycle valid strobe starts a conversion. A new conversion may start on every cycle. The first stage extends the operand, takes its magnitude, counts its leading zeros and normalises it. The second stage rounds under the 2-bit dynamic rounding mode, packs the result and classifies it. The result, the inexact flag and a 5-bit class-and-sign code appear together with a one-cycle done strobe. They hold their values until the next result arrives.

Top module: `i2f_convert`

## Requirements
- R1: The done strobe `out_valid` rises exactly two clock cycles after `in_valid` is sampled high. It stays high for one cycle for each accepted conversion, and back-to-back strobes produce back-to-back results.
- R2: When `in_wide` is 0, only bits 31:0 of `in_int` are used. They are sign-extended when `in_signed` is 1 and zero-extended when it is 0, and bits 63:32 have no effect on the result.
- R3: A double-precision conversion of any integer whose magnitude fits in 53 bits is exact and leaves `out_inexact` at 0.
- R4: `rnd_mode` selects the rounding direction. 2'b00 rounds to nearest with ties to even, 2'b01 rounds toward zero, 2'b10 rounds toward +infinity, and 2'b11 rounds toward -infinity.
- R5: When `in_single` is 1, the result is rounded to a 24-bit significand and written as an exact double, so bits 28:0 of `out_result` are 0.
- R6: A zero operand gives `out_result` = 64'h0 (+0.0), `out_inexact` = 0 and class 5'b00010.
- R7: The signed 64-bit operand 64'h8000_0000_0000_0000 converts exactly to -2^63 (64'hC3E0_0000_0000_0000).
- R8: When rounding carries out of the significand, the exponent rises by one and the fraction becomes zero. For example, unsigned 2^64-1 converted to double with round-to-nearest gives 64'h43F0_0000_0000_0000.
- R9: `out_class` is 5'b00100 for a positive nonzero result and 5'b01000 for a negative one, and bit 63 of `out_result` is the sign.
- R10: `out_inexact` is 1 exactly when nonzero bits were dropped during rounding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Starts a conversion in this cycle |
| in_int | input | 64 | Integer operand (general register contents) |
| in_wide | input | 1 | 1: 64-bit source, 0: low 32 bits |
| in_signed | input | 1 | 1: two's complement source, 0: unsigned |
| in_single | input | 1 | 1: round to single precision, 0: double |
| rnd_mode | input | 2 | Dynamic rounding mode (encoding in R4) |
| out_valid | output | 1 | One-cycle done strobe |
| out_result | output | 64 | Result in double-precision format |
| out_inexact | output | 1 | Rounding dropped nonzero bits |
| out_class | output | 5 | Result class and sign code |

## Verification
The hardest cases to reach from the ports are the ones where rounding moves the value across a binade boundary. There the significand carries out and the exponent must increase by one. The stimulus reaches them with all-ones magnitudes: 2^64-1 to double and 2^32-1 to single. It also places exact ties at 2^53+1 and 2^53+3 and uses negative operands, so that each rounding direction can be told apart by a single last bit. The extension rules are exercised by 32-bit sources whose upper register half holds unrelated bits.

// File: rtl/i2f_pkg.sv
package i2f_pkg;
    localparam int INT_W      = 64;
    localparam int EXP_W      = 11;
    localparam int FRAC_W     = 52;
    localparam int SGL_FRAC_W = 23;
    localparam int BIAS       = 1023;
    localparam int LZ_W       = $clog2(INT_W);
    localparam int CLS_W      = 5;
    localparam int RES_W      = 1 + EXP_W + FRAC_W;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'b00,
        RM_ZERO    = 2'b01,
        RM_POS     = 2'b10,
        RM_NEG     = 2'b11
    } rmode_e;

    localparam logic [CLS_W-1:0] CLS_PZERO = 5'b00010;
    localparam logic [CLS_W-1:0] CLS_PNORM = 5'b00100;
    localparam logic [CLS_W-1:0] CLS_NNORM = 5'b01000;

    typedef struct packed {
        logic             valid;
        logic             neg;
        logic             zero;
        logic [INT_W-1:0] norm;
        logic [LZ_W-1:0]  msb;
        logic             single;
        rmode_e           rm;
    } norm_stage_t;

    typedef struct packed {
        logic             valid;
        logic [RES_W-1:0] result;
        logic             inexact;
        logic [CLS_W-1:0] cls;
    } out_stage_t;
endpackage

// File: rtl/i2f_operand.sv
module i2f_operand #(
    parameter int INT_W = 64
) (
    input  logic [INT_W-1:0] raw,
    input  logic             wide,
    input  logic             sgn,
    output logic             neg,
    output logic [INT_W-1:0] mag
);
    localparam int HALF = INT_W / 2;

    logic [INT_W-1:0] ext;

    always_comb begin
        if (wide) begin
            ext = raw;
        end else if (sgn) begin
            ext = {{HALF{raw[HALF-1]}}, raw[HALF-1:0]};
        end else begin
            ext = {{HALF{1'b0}}, raw[HALF-1:0]};
        end
        neg = sgn & ext[INT_W-1];
        // Negating the most negative value wraps to itself, which reads
        // correctly as the unsigned magnitude 2^(INT_W-1).
        mag = neg ? (~ext + INT_W'(1)) : ext;
    end
endmodule

// File: rtl/i2f_lzc.sv
module i2f_lzc #(
    parameter int W  = 64,
    parameter int CW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] msb
);
    always_comb begin
        msb = '0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) msb = CW'(i);
        end
    end
endmodule

// File: rtl/i2f_round.sv
module i2f_round
    import i2f_pkg::*;
(
    input  logic             neg,
    input  logic             zero,
    input  logic [INT_W-1:0] norm,
    input  logic [LZ_W-1:0]  msb,
    input  logic             single,
    input  rmode_e           rm,
    output logic [RES_W-1:0] result,
    output logic             inexact,
    output logic [CLS_W-1:0] cls
);
    localparam int MW  = FRAC_W + 1;
    localparam int PAD = FRAC_W - SGL_FRAC_W;
    localparam int G_D = INT_W - MW - 1;
    localparam int G_S = INT_W - SGL_FRAC_W - 2;
    localparam logic [MW-1:0] LOW_MASK = MW'((64'd1 << PAD) - 64'd1);
    localparam logic [MW-1:0] INC_S    = MW'(64'd1 << PAD);

    logic [MW-1:0]    mant_d;
    logic [MW-1:0]    keep;
    logic [MW-1:0]    inc;
    logic             lsb, guard, sticky, loss, up, carry;
    logic [MW:0]      sum;
    logic [EXP_W-1:0] exp_b;
    logic [FRAC_W-1:0] frac;

    assign mant_d = norm[INT_W-1 -: MW];

    always_comb begin
        if (single) begin
            keep   = mant_d & ~LOW_MASK;
            inc    = INC_S;
            lsb    = norm[G_S+1];
            guard  = norm[G_S];
            sticky = |(norm << (SGL_FRAC_W + 2));
        end else begin
            keep   = mant_d;
            inc    = MW'(1);
            lsb    = norm[G_D+1];
            guard  = norm[G_D];
            sticky = |(norm << (FRAC_W + 2));
        end
        loss = guard | sticky;
        unique case (rm)
            RM_NEAREST: up = guard & (sticky | lsb);
            RM_ZERO:    up = 1'b0;
            RM_POS:     up = loss & ~neg;
            RM_NEG:     up = loss & neg;
            default:    up = 1'b0;
        endcase
        sum   = {1'b0, keep} + (up ? {1'b0, inc} : '0);
        carry = sum[MW];
        exp_b = EXP_W'(msb) + EXP_W'(BIAS) + EXP_W'(carry);
        frac  = carry ? '0 : sum[FRAC_W-1:0];
        if (zero) begin
            result  = '0;
            inexact = 1'b0;
            cls     = CLS_PZERO;
        end else begin
            result  = {neg, exp_b, frac};
            inexact = loss;
            cls     = neg ? CLS_NNORM : CLS_PNORM;
        end
    end
endmodule

// File: rtl/i2f_convert.sv
module i2f_convert
    import i2f_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [63:0] in_int,
    input  logic        in_wide,
    input  logic        in_signed,
    input  logic        in_single,
    input  logic [1:0]  rnd_mode,
    output logic        out_valid,
    output logic [63:0] out_result,
    output logic        out_inexact,
    output logic [4:0]  out_class
);
    localparam int PAD = FRAC_W - SGL_FRAC_W;

    norm_stage_t s1_d, s1_q;
    out_stage_t  s2_d, s2_q;

    logic             op_neg;
    logic [INT_W-1:0] op_mag;
    logic [LZ_W-1:0]  op_msb;
    logic [RES_W-1:0] rd_result;
    logic             rd_inexact;
    logic [CLS_W-1:0] rd_cls;

    i2f_operand #(.INT_W(INT_W)) u_operand (
        .raw  (in_int),
        .wide (in_wide),
        .sgn  (in_signed),
        .neg  (op_neg),
        .mag  (op_mag)
    );

    i2f_lzc #(.W(INT_W), .CW(LZ_W)) u_lzc (
        .vec (op_mag),
        .msb (op_msb)
    );

    i2f_round u_round (
        .neg     (s1_q.neg),
        .zero    (s1_q.zero),
        .norm    (s1_q.norm),
        .msb     (s1_q.msb),
        .single  (s1_q.single),
        .rm      (s1_q.rm),
        .result  (rd_result),
        .inexact (rd_inexact),
        .cls     (rd_cls)
    );

    always_comb begin
        s1_d       = s1_q;
        s1_d.valid = in_valid;
        if (in_valid) begin
            s1_d.neg    = op_neg;
            s1_d.zero   = (op_mag == '0);
            s1_d.msb    = op_msb;
            s1_d.norm   = op_mag << (LZ_W'(INT_W - 1) - op_msb);
            s1_d.single = in_single;
            s1_d.rm     = rmode_e'(rnd_mode);
        end

        s2_d       = s2_q;
        s2_d.valid = s1_q.valid;
        if (s1_q.valid) begin
            s2_d.result  = rd_result;
            s2_d.inexact = rd_inexact;
            s2_d.cls     = rd_cls;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign out_valid   = s2_q.valid;
    assign out_result  = s2_q.result;
    assign out_inexact = s2_q.inexact;
    assign out_class   = s2_q.cls;

    assert_done_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        s1_q.valid |=> out_valid);
    assert_no_spurious_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_q.valid |=> !out_valid);
    assert_exact_narrow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_q.valid && !s1_q.single && s1_q.msb <= LZ_W'(FRAC_W)) |=> !out_inexact);
    assert_single_low_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_q.valid && s1_q.single) |=> (out_result[PAD-1:0] == '0));
    assert_zero_exact_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_class == CLS_PZERO) |-> (out_result == '0 && !out_inexact));
    assert_sign_class_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_class != CLS_PZERO) |-> (out_result[63] == (out_class == CLS_NNORM)));
endmodule

// File: tb/i2f_convert_bench.sv
module i2f_convert_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_int = '0;
    logic        in_wide = 1'b0;
    logic        in_signed = 1'b0;
    logic        in_single = 1'b0;
    logic [1:0]  rnd_mode = 2'b00;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_inexact;
    logic [4:0]  out_class;

    int n_total = 0;
    int n_fail  = 0;
    bit ended   = 1'b0;

    localparam logic [4:0] PZ = 5'b00010, PN = 5'b00100, NN = 5'b01000;

    always #2 clk = ~clk;

    i2f_convert u_i2f_convert (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_int(in_int),
        .in_wide(in_wide), .in_signed(in_signed), .in_single(in_single),
        .rnd_mode(rnd_mode), .out_valid(out_valid), .out_result(out_result),
        .out_inexact(out_inexact), .out_class(out_class)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    endtask

    // One conversion: drive at negedge, result visible after the second edge.
    task automatic conv(input logic [63:0] v, input logic w, input logic s,
                        input logic sg, input logic [1:0] rm, input string req,
                        input logic [63:0] e_res, input logic e_inx, input logic [4:0] e_cls);
        @(negedge clk);
        in_int = v; in_wide = w; in_signed = s; in_single = sg; rnd_mode = rm;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        in_int = ~v;
        check({req, " R1 early done"}, 64'(out_valid), 64'd0);
        @(negedge clk);
        check({req, " R1 done"}, 64'(out_valid), 64'd1);
        check({req, " result"}, out_result, e_res);
        check({req, " R10 inexact"}, 64'(out_inexact), 64'(e_inx));
        check({req, " R9 class"}, 64'(out_class), 64'(e_cls));
    endtask

    task automatic t_reset();
        check("R1 reset done low", 64'(out_valid), 64'd0);
        check("R6 reset result", out_result, 64'd0);
    endtask

    task automatic t_zero();
        conv(64'd0, 1'b1, 1'b1, 1'b0, 2'b10, "R6 zero", 64'h0, 1'b0, PZ);
        conv(64'hFFFF_FFFF_0000_0000, 1'b0, 1'b1, 1'b1, 2'b11, "R6 zero low half", 64'h0, 1'b0, PZ);
    endtask

    task automatic t_extend();
        conv(64'hDEAD_BEEF_FFFF_FFFF, 1'b0, 1'b1, 1'b0, 2'b00, "R2 signed -1", 64'hBFF0_0000_0000_0000, 1'b0, NN);
        conv(64'h1234_5678_FFFF_FFFF, 1'b0, 1'b0, 1'b0, 2'b00, "R2 R3 unsigned 2^32-1", 64'h41EF_FFFF_FFE0_0000, 1'b0, PN);
        conv(64'hDEAD_BEEF_0000_0005, 1'b0, 1'b1, 1'b0, 2'b00, "R2 positive 5", 64'h4014_0000_0000_0000, 1'b0, PN);
        conv(64'd1, 1'b1, 1'b0, 1'b0, 2'b01, "R3 one", 64'h3FF0_0000_0000_0000, 1'b0, PN);
    endtask

    task automatic t_modes();
        conv(64'h0020_0000_0000_0001, 1'b1, 1'b0, 1'b0, 2'b00, "R4 tie even down", 64'h4340_0000_0000_0000, 1'b1, PN);
        conv(64'h0020_0000_0000_0003, 1'b1, 1'b0, 1'b0, 2'b00, "R4 tie even up", 64'h4340_0000_0000_0002, 1'b1, PN);
        conv(64'h0020_0000_0000_0001, 1'b1, 1'b0, 1'b0, 2'b01, "R4 toward zero", 64'h4340_0000_0000_0000, 1'b1, PN);
        conv(64'h0020_0000_0000_0001, 1'b1, 1'b0, 1'b0, 2'b10, "R4 toward +inf", 64'h4340_0000_0000_0001, 1'b1, PN);
        conv(64'h0020_0000_0000_0001, 1'b1, 1'b0, 1'b0, 2'b11, "R4 toward -inf", 64'h4340_0000_0000_0000, 1'b1, PN);
        conv(64'hFFDF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 1'b0, 2'b10, "R4 neg +inf", 64'hC340_0000_0000_0000, 1'b1, NN);
        conv(64'hFFDF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 1'b0, 2'b11, "R4 neg -inf", 64'hC340_0000_0000_0001, 1'b1, NN);
    endtask

    task automatic t_single();
        conv(64'h0000_0000_0100_0001, 1'b1, 1'b0, 1'b1, 2'b00, "R5 single nearest", 64'h4170_0000_0000_0000, 1'b1, PN);
        conv(64'h0000_0000_0100_0001, 1'b1, 1'b0, 1'b1, 2'b10, "R5 single +inf", 64'h4170_0000_2000_0000, 1'b1, PN);
        conv(64'h0000_0000_0100_0001, 1'b1, 1'b0, 1'b0, 2'b00, "R3 double same value", 64'h4170_0000_1000_0000, 1'b0, PN);
        conv(64'h0000_0000_FFFF_FFFF, 1'b0, 1'b0, 1'b1, 2'b01, "R5 single toward zero", 64'h41EF_FFFF_E000_0000, 1'b1, PN);
    endtask

    task automatic t_extremes();
        conv(64'h8000_0000_0000_0000, 1'b1, 1'b1, 1'b0, 2'b00, "R7 most negative", 64'hC3E0_0000_0000_0000, 1'b0, NN);
        conv(64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 1'b0, 2'b00, "R8 carry double", 64'h43F0_0000_0000_0000, 1'b1, PN);
        conv(64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 1'b0, 2'b01, "R8 no carry", 64'h43EF_FFFF_FFFF_FFFF, 1'b1, PN);
        conv(64'h0000_0000_FFFF_FFFF, 1'b0, 1'b0, 1'b1, 2'b00, "R8 carry single", 64'h41F0_0000_0000_0000, 1'b1, PN);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        in_int = 64'd1; in_wide = 1'b1; in_signed = 1'b0; in_single = 1'b0; rnd_mode = 2'b00;
        in_valid = 1'b1;
        @(negedge clk);
        in_int = 64'hFFFF_FFFF_FFFF_FFFE; in_signed = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R1 b2b first done", 64'(out_valid), 64'd1);
        check("R1 b2b first result", out_result, 64'h3FF0_0000_0000_0000);
        @(negedge clk);
        check("R1 b2b second done", 64'(out_valid), 64'd1);
        check("R1 b2b second result", out_result, 64'hC000_0000_0000_0000);
        @(negedge clk);
        check("R1 b2b done drops", 64'(out_valid), 64'd0);
        check("R1 result held", out_result, 64'hC000_0000_0000_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_zero();
        t_extend();
        t_modes();
        t_single();
        t_extremes();
        t_back_to_back();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule